// File: doc/BRIEF.md
# Aligned Multi-Ratio Clock Divider

This block takes one input clock and produces a set of derived clocks: half, one quarter and one eighth of the input frequency in the default three-stage build. All outputs are bits of a single synchronous state register that advances on the rising input edge. Every output therefore changes on the same input edge, and where two outputs share an edge they switch together.

A single active-low run input starts and stops the whole chain. The run input is captured by a register on the falling input edge. A change in run therefore takes effect only while the input clock is low. The divider either takes a complete rising edge or none, and no output can show a shortened pulse.

A synchronous, active-high reset clears the divider state and the captured run flag. This puts every copy of the block in a system into the same phase. When reset is released with run active, the first counted rising edge drives all outputs high at once.

Top module: `aligned_clk_divider`

## Requirements
- R1: A rising input edge with `rst` high sets every bit of `div_out` to 0. A falling input edge with `rst` high clears the captured run flag. If `rst` falls just after a falling edge, the next rising edge therefore leaves `div_out` at 0.
- R2: The state counts down modulo 2^STAGES, and `div_out[k]` is state bit k. On each rising edge where the captured run flag is set and `rst` is low, the state decreases by one. So the first counted edge after reset makes every output 1 (value 7 for three stages).
- R3: While running without interruption, `div_out[k]` toggles exactly every 2^k input cycles. Its period is 2^(k+1) input cycles with equal high and low times.
- R4: Whenever `div_out[k]` changes for k of 1 or more, `div_out[k-1]` changes on the same rising input edge.
- R5: `run_n` is sampled only on the falling input edge, and 0 means run. A pulse on `run_n` that begins and ends between two falling edges has no effect. A change made after a falling edge does not affect the rising edge that follows it.
- R6: On a rising edge where the captured run flag is clear, every output holds its level.
- R7: Any level on `div_out[k]` between two changes, with no reset in between, lasts at least 2^k input cycles, however `run_n` is toggled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset of state and run flag |
| run_n | input | 1 | Active-low run request, captured on the falling edge |
| div_out | output | STAGES | Bit k is the input clock divided by 2^(k+1) |

## Verification
A corrupted state bit shows at once. `div_out` carries the state directly, so a wrong value appears at the ports on the rising edge that produced it, and the bench compares against a count of run-enabled edges every cycle. A run flag captured on the wrong edge or left uncleared by reset shows within one rising edge: a step appears where a hold was expected, or the reverse. A broken alignment between stages appears as a lone change on a slower output at the next edge where that output toggles.

// File: rtl/aligned_clk_divider_pkg.sv
package aligned_clk_divider_pkg;

    // Captured state of the run request.
    typedef enum logic {
        DIV_HOLD = 1'b0,
        DIV_RUN  = 1'b1
    } run_e;

    localparam int DEFAULT_STAGES = 3;

    // Map the active-low request pin onto the run state.
    function automatic run_e decode_run(input logic req_n);
        return req_n ? DIV_HOLD : DIV_RUN;
    endfunction

endpackage

// File: rtl/div_run_capture.sv
module div_run_capture
    import aligned_clk_divider_pkg::*;
(
    input  logic clk_in,
    input  logic rst,
    input  logic run_n,
    output run_e run_state
);

    // Falling-edge capture: changes land only while the clock is low.
    always_ff @(negedge clk_in) begin
        if (rst) begin
            run_state <= DIV_HOLD;
        end else begin
            run_state <= decode_run(run_n);
        end
    end

endmodule

// File: rtl/div_state_counter.sv
module div_state_counter #(
    parameter int STAGES = 3
) (
    input  logic              clk_in,
    input  logic              rst,
    input  logic              step,
    output logic [STAGES-1:0] state
);

    localparam logic [STAGES-1:0] ONE = STAGES'(1);

    always_ff @(posedge clk_in) begin
        if (rst) begin
            state <= '0;
        end else if (step) begin
            state <= state - ONE;
        end
    end

endmodule

// File: rtl/div_tap_map.sv
module div_tap_map #(
    parameter int STAGES = 3
) (
    input  logic [STAGES-1:0] state,
    output logic [STAGES-1:0] taps
);

    // Bit k of the shared state is the divide-by-2^(k+1) clock.
    for (genvar k = 0; k < STAGES; k++) begin : g_tap
        assign taps[k] = state[k];
    end

endmodule

// File: rtl/aligned_clk_divider.sv
module aligned_clk_divider
    import aligned_clk_divider_pkg::*;
#(
    parameter int STAGES = DEFAULT_STAGES
) (
    input  logic              clk_in,
    input  logic              rst,
    input  logic              run_n,
    output logic [STAGES-1:0] div_out
);

    run_e              run_state;
    logic              run_q;
    logic [STAGES-1:0] state;

    div_run_capture u_capture (
        .clk_in    (clk_in),
        .rst       (rst),
        .run_n     (run_n),
        .run_state (run_state)
    );

    assign run_q = (run_state == DIV_RUN);

    div_state_counter #(.STAGES(STAGES)) u_counter (
        .clk_in (clk_in),
        .rst    (rst),
        .step   (run_q),
        .state  (state)
    );

    div_tap_map #(.STAGES(STAGES)) u_taps (
        .state (state),
        .taps  (div_out)
    );

endmodule

// File: rtl/aligned_clk_divider_chk.sv
module aligned_clk_divider_chk #(
    parameter int STAGES = 3
) (
    input logic              clk_in,
    input logic              rst,
    input logic              run_n,
    input logic              run_q,
    input logic [STAGES-1:0] div_out
);

    localparam logic [STAGES-1:0] ONE = STAGES'(1);

    // R1: a reset edge leaves all outputs low
    a_r1_reset_clears: assert property (@(posedge clk_in)
        rst |=> (div_out == '0));

    // R2: a counted edge lowers the state by one
    a_r2_count_down: assert property (@(posedge clk_in) disable iff (rst)
        run_q |=> (div_out == $past(div_out) - ONE));

    // R6: no capture, no movement
    a_r6_hold: assert property (@(posedge clk_in) disable iff (rst)
        !run_q |=> $stable(div_out));

    // R5: the run flag follows the request seen at the previous falling edge
    a_r5_fall_capture: assert property (@(negedge clk_in) disable iff (rst)
        !rst |=> (run_q == !$past(run_n)));

    // R4: a slower output never changes alone
    for (genvar k = 1; k < STAGES; k++) begin : g_align
        a_r4_aligned: assert property (@(posedge clk_in) disable iff (rst)
            (div_out[k] != $past(div_out[k])) |-> (div_out[k-1] != $past(div_out[k-1])));
    end

endmodule

bind aligned_clk_divider aligned_clk_divider_chk #(.STAGES(STAGES)) u_chk (
    .clk_in  (clk_in),
    .rst     (rst),
    .run_n   (run_n),
    .run_q   (run_q),
    .div_out (div_out)
);

// File: tb/test_aligned_clk_divider.sv
module test_aligned_clk_divider;

    localparam int CLK_PERIOD = 10;
    localparam int N = 3;

    logic         clk_in = 1'b0;
    logic         rst = 1'b1;
    logic         run_n = 1'b0;
    logic [N-1:0] div_out;

    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 0;
    logic [N-1:0] cnt_m = '0;
    logic [N-1:0] prev_out = '0;
    bit           en_m = 0;
    int           run_len [N];
    bit           run_ok  [N];
    bit           run_held[N];

    always #(CLK_PERIOD/2) clk_in = ~clk_in;

    aligned_clk_divider #(.STAGES(N)) i_aligned_clk_divider (
        .clk_in  (clk_in),
        .rst     (rst),
        .run_n   (run_n),
        .div_out (div_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // act: 0 plain, 1 flip run_n just after the fall, 2 release reset just after the fall
    task automatic cycle(input int act);
        @(negedge clk_in);
        en_m = rst ? 1'b0 : !run_n;
        if (act == 1) begin #1 run_n = !run_n; end
        if (act == 2) begin #1 rst = 1'b0; end
        @(posedge clk_in);
        if (rst) cnt_m = '0;
        else if (en_m) cnt_m = cnt_m - 1'b1;
        #1;
        check(div_out === cnt_m, "R2 state", int'(div_out), int'(cnt_m));
        if (rst || act == 2) check(div_out === '0, "R1 cleared", int'(div_out), 0);
        if (act == 1) check(div_out === cnt_m, "R5 late change ignored", int'(div_out), int'(cnt_m));
        if (!rst && !en_m) check(div_out === prev_out, "R6 frozen", int'(div_out), int'(prev_out));
        for (int k = 0; k < N; k++) begin
            if (rst) begin
                run_ok[k] = 0; run_len[k] = 0; run_held[k] = 0;
            end else begin
                run_len[k]++;
                if (!en_m) run_held[k] = 1;
                if (div_out[k] !== prev_out[k]) begin
                    if (run_ok[k]) begin
                        check(run_len[k] >= (1 << k), $sformatf("R7 min width bit%0d", k), run_len[k], 1 << k);
                        if (!run_held[k])
                            check(run_len[k] == (1 << k), $sformatf("R3 half period bit%0d", k), run_len[k], 1 << k);
                    end
                    if (k > 0)
                        check(div_out[k-1] !== prev_out[k-1], $sformatf("R4 align bit%0d", k), int'(div_out), int'(prev_out));
                    run_ok[k] = 1; run_len[k] = 0; run_held[k] = 0;
                end
            end
        end
        prev_out = div_out;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) cycle(0);
        // Reset dropped just after a fall: the run flag is still clear (R1)
        cycle(2);
        cycle(0);
        check(div_out === 3'b111, "R2 first edge all high", int'(div_out), 7);
        // Free run: periods and alignment (R3, R4)
        for (int i = 0; i < 48; i++) cycle(0);
        // Hold (R6)
        run_n = 1'b1;
        for (int i = 0; i < 10; i++) cycle(0);
        run_n = 1'b0;
        for (int i = 0; i < 16; i++) cycle(0);
        // Short pulses between falls are not seen (R5)
        for (int i = 0; i < 8; i++) begin
            #1 run_n = 1'b1;
            #2 run_n = 1'b0;
            cycle(0);
        end
        // Random toggling, early and late in the low phase (R5, R7)
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 7));
            if (r == 0) run_n = !run_n;
            cycle(r == 1 ? 1 : 0);
        end
        // Mid-run reset while disabled, then release and restart (R1)
        run_n = 1'b1;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) cycle(0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) cycle(0);
        check(div_out === '0, "R1 held at zero until run", int'(div_out), 0);
        run_n = 1'b0;
        for (int i = 0; i < 24; i++) cycle(0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule